// File: doc/BRIEF.md
# Bank and Sector Write-Protection Decoder

This block sits beside the command logic of a four-bank flash array. It turns a 22-bit word address into a bank number and a sector index. Each bank covers one megaword. The lowest and the highest bank each carry four small boot sectors at the outer end of the address range. It decides in the same cycle whether that sector may be programmed or erased.

Protection comes from three sources. Each sector has its own lock bit, which lock and unlock requests set and clear. A write-protect pin guards the two outermost boot sectors at one end. An acceleration pin, when low, treats every sector as locked.

A program or erase request that is accepted marks its bank as busy until the algorithm reports completion. A read address is compared with the busy bank every cycle. A match is flagged so that status data, rather than array data, can be returned. Reads to any other bank are never flagged and add no latency.

Top module: `bank_sector_guard`

## Requirements
- R1: The bank is the two top address bits `req_addr_i[21:20]`. An accepted request loads this bank into `busy_bank_o`.
- R2: With hi = addr[19:15] and sub = addr[14:13], the sector index `sector_o` is derived as follows. In bank 0, hi = 0 gives sector sub (0..3) and any other hi gives 3 + hi. In banks 1 and 2 it is 35 + 32*(bank-1) + hi. In bank 3, hi below 31 gives 99 + hi.
- R3: In bank 3, hi = 31 selects the top boot sectors 130 + sub (130..133). Their lock bits behave like any other sector's.
- R4: Op code 2 sets the lock bit of the addressed sector and op code 3 clears it, effective from the next cycle. `locked_o` shows protection for `req_addr_i` combinationally. All lock bits are clear after reset.
- R5: A program (op 0) or erase (op 1) request to a protected sector gives a one-cycle `err_o` pulse in the next cycle. There is no `grant_o` and the busy state is unchanged.
- R6: While `wp_ni` is low, sectors 0 and 1 are protected whatever their lock bits hold (default WP_TOP = 0). While `wp_ni` is high the pin has no effect.
- R7: While `acc_ni` is low, every sector reads as protected and every program or erase request is rejected.
- R8: A program or erase request to an unprotected sector while idle gives a one-cycle `grant_o` in the next cycle, with `busy_o` high. `op_done_i` clears `busy_o` at the next edge.
- R9: A program or erase request while `busy_o` is high is rejected with `err_o`, and busy state and bank are kept.
- R10: `rd_status_o` is high exactly when `busy_o` is high and `rd_addr_i[21:20]` equals `busy_bank_o`. It is combinational.
- R11: Lock and unlock requests produce neither `grant_o` nor `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, one cycle per request |
| req_op_i | input | 2 | 0 program, 1 erase, 2 lock, 3 unlock |
| req_addr_i | input | 22 | Word address of the request |
| wp_ni | input | 1 | Write-protect pin, active low |
| acc_ni | input | 1 | Acceleration pin; low locks all sectors |
| op_done_i | input | 1 | Program or erase finished |
| rd_addr_i | input | 22 | Word address of the current read |
| sector_o | output | 8 | Decoded sector index of req_addr_i |
| locked_o | output | 1 | Sector of req_addr_i is protected |
| grant_o | output | 1 | Request accepted (pulse) |
| err_o | output | 1 | Request rejected (pulse) |
| busy_o | output | 1 | A program or erase is in progress |
| busy_bank_o | output | 2 | Bank of the operation in progress |
| rd_status_o | output | 1 | Read targets the busy bank |

## Verification
The assertions assume that `req_op_i` and `req_addr_i` are stable around the clock edge at which `req_valid_i` is sampled. They also assume that `op_done_i` is raised only while an operation is in progress. The stimulus follows both rules: it changes inputs only on the falling edge and raises `op_done_i` only after a grant. The pins `wp_ni` and `acc_ni` are treated as quasi-static and are changed only between requests, never in the cycle a request is sampled.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_ERASE  = 2'd1,
    OP_LOCK   = 2'd2,
    OP_UNLOCK = 2'd3
  } bsg_op_e;
endpackage

// File: rtl/bsg_sector_map.sv
module bsg_sector_map #(
  parameter int ADDR_W  = 22,
  parameter int BANK_W  = 2,
  parameter int BIG_W   = 15,
  parameter int SMALL_W = 13,
  parameter int SEC_W   = 8
) (
  input  logic [ADDR_W-SMALL_W-1:0] addr_hi_i,
  output logic [BANK_W-1:0]         bank_o,
  output logic [SEC_W-1:0]          sector_o
);
  localparam int OFF_W    = ADDR_W - BANK_W;
  localparam int HI_W     = OFF_W - BIG_W;
  localparam int SUB_W    = BIG_W - SMALL_W;
  localparam int BOOT     = 2 ** SUB_W;
  localparam int PER_BANK = 2 ** HI_W;
  localparam int NBANK    = 2 ** BANK_W;

  logic [HI_W-1:0]  hi;
  logic [SUB_W-1:0] sub;
  logic [SEC_W-1:0] base;
  logic             low_boot, top_boot;

  always_comb begin
    bank_o   = addr_hi_i[ADDR_W-SMALL_W-1 -: BANK_W];
    hi       = addr_hi_i[BIG_W-SMALL_W +: HI_W];
    sub      = addr_hi_i[SUB_W-1:0];
    // bank*PER_BANK + hi, shifted past the extra boot sectors of bank 0
    base     = SEC_W'(BOOT - 1) + SEC_W'({bank_o, hi});
    low_boot = (bank_o == '0) && (hi == '0);
    top_boot = (bank_o == BANK_W'(NBANK - 1)) && (hi == HI_W'(PER_BANK - 1));
    if (low_boot)      sector_o = SEC_W'(sub);
    else if (top_boot) sector_o = base + SEC_W'(sub);
    else               sector_o = base;
  end
endmodule

// File: rtl/bsg_lock_bits.sv
module bsg_lock_bits #(
  parameter int NUM_SEC = 134,
  parameter int SEC_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_i,
  input  logic               clr_i,
  input  logic [SEC_W-1:0]   sel_i,
  output logic [NUM_SEC-1:0] lock_o
);
  for (genvar g = 0; g < NUM_SEC; g++) begin : g_bit
    logic hit;
    assign hit = (sel_i == SEC_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           lock_o[g] <= 1'b0;
      else if (set_i && hit) lock_o[g] <= 1'b1;
      else if (clr_i && hit) lock_o[g] <= 1'b0;
    end
  end

  // R4
  lock_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> lock_o[$past(sel_i)]);
  // R4
  lock_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !lock_o[$past(sel_i)]);
endmodule

// File: rtl/bsg_busy_bank.sv
module bsg_busy_bank #(
  parameter int BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              done_i,
  output logic              busy_o,
  output logic [BANK_W-1:0] bank_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      bank_o <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      bank_o <= bank_i;
    end else if (done_i) begin
      busy_o <= 1'b0;
    end
  end

  // R8
  done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !start_i) |=> !busy_o);
  // R1
  start_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_o && bank_o == $past(bank_i)));
endmodule

// File: rtl/bank_sector_guard.sv
module bank_sector_guard
  import bsg_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int BANK_W  = 2,
  parameter int BIG_W   = 15,
  parameter int SMALL_W = 13,
  parameter bit WP_TOP  = 1'b0,
  localparam int HI_W    = ADDR_W - BANK_W - BIG_W,
  localparam int SUB_W   = BIG_W - SMALL_W,
  localparam int NUM_SEC = (2 ** BANK_W) * (2 ** HI_W) - 2 + 2 * (2 ** SUB_W),
  localparam int SEC_W   = $clog2(NUM_SEC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              wp_ni,
  input  logic              acc_ni,
  input  logic              op_done_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [SEC_W-1:0]  sector_o,
  output logic              locked_o,
  output logic              grant_o,
  output logic              err_o,
  output logic              busy_o,
  output logic [BANK_W-1:0] busy_bank_o,
  output logic              rd_status_o
);
  bsg_op_e           op;
  logic [BANK_W-1:0] req_bank;
  logic [NUM_SEC-1:0] lock_vec;
  logic              wp_hit, pe_req, accept, reject;
  logic              unused_bits;

  assign op          = bsg_op_e'(req_op_i);
  assign unused_bits = ^{req_addr_i[SMALL_W-1:0], rd_addr_i[ADDR_W-BANK_W-1:0]};

  bsg_sector_map #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .BIG_W(BIG_W),
    .SMALL_W(SMALL_W), .SEC_W(SEC_W)
  ) u_map (
    .addr_hi_i(req_addr_i[ADDR_W-1:SMALL_W]),
    .bank_o   (req_bank),
    .sector_o (sector_o)
  );

  bsg_lock_bits #(.NUM_SEC(NUM_SEC), .SEC_W(SEC_W)) u_locks (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (req_valid_i && op == OP_LOCK),
    .clr_i (req_valid_i && op == OP_UNLOCK),
    .sel_i (sector_o),
    .lock_o(lock_vec)
  );

  if (WP_TOP) begin : g_wp_top
    assign wp_hit = (sector_o >= SEC_W'(NUM_SEC - 2));
  end else begin : g_wp_bot
    assign wp_hit = (sector_o < SEC_W'(2));
  end

  assign locked_o = lock_vec[sector_o] || !acc_ni || (!wp_ni && wp_hit);
  assign pe_req   = req_valid_i && (op == OP_PROG || op == OP_ERASE);
  assign accept   = pe_req && !locked_o && !busy_o;
  assign reject   = pe_req && (locked_o || busy_o);

  bsg_busy_bank #(.BANK_W(BANK_W)) u_busy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .bank_i (req_bank),
    .done_i (op_done_i),
    .busy_o (busy_o),
    .bank_o (busy_bank_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      grant_o <= accept;
      err_o   <= reject;
    end
  end

  assign rd_status_o = busy_o && (rd_addr_i[ADDR_W-1 -: BANK_W] == busy_bank_o);

  // R2
  sector_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sector_o < SEC_W'(NUM_SEC));
  // R5
  prot_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pe_req && locked_o) |=> (err_o && !grant_o));
  // R7
  acc_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_ni |-> locked_o);
  // R8
  grant_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> busy_o);
  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pe_req && busy_o && !op_done_i) |=> (busy_o && $stable(busy_bank_o) && err_o));
  // R10
  rd_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_status_o |-> busy_o);
  // R11
  lock_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (op == OP_LOCK || op == OP_UNLOCK)) |=> (!grant_o && !err_o));
endmodule

// File: tb/bank_sector_guard_bench.sv
`timescale 1ns/1ps
module bank_sector_guard_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_op_i = 2'd0;
  logic [21:0] req_addr_i = '0;
  logic        wp_ni = 1'b1;
  logic        acc_ni = 1'b1;
  logic        op_done_i = 1'b0;
  logic [21:0] rd_addr_i = '0;
  logic [7:0]  sector_o;
  logic        locked_o, grant_o, err_o, busy_o, rd_status_o;
  logic [1:0]  busy_bank_o;

  always #10 clk_i = ~clk_i;

  bank_sector_guard u_bank_sector_guard (.*);

  typedef struct {
    bit         grant;
    bit         err;
    bit         busy;
    logic [1:0] bank;
    string      tag;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    m_lock[134];
  bit    m_busy = 0;
  logic [1:0] m_bank = 0;
  bit    done_flag = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_sector(logic [21:0] a);
    int b = a[21:20];
    int h = a[19:15];
    int s = a[14:13];
    if (b == 0) return (h == 0) ? s : 3 + h;
    if (b == 3) return (h == 31) ? 130 + s : 99 + h;
    return 35 + 32 * (b - 1) + h;
  endfunction

  function automatic bit ref_prot(logic [21:0] a);
    int s = ref_sector(a);
    return m_lock[s] || !acc_ni || (!wp_ni && s < 2);
  endfunction

  task automatic look(logic [21:0] a, string req);
    @(negedge clk_i);
    req_addr_i = a;
    #2;
    chk(locked_o === ref_prot(a), req, "locked_o", int'(locked_o), int'(ref_prot(a)));
  endtask

  task automatic do_req(logic [1:0] op, logic [21:0] a, string req);
    item_t it;
    bit prot;
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_op_i    = op;
    req_addr_i  = a;
    prot = ref_prot(a);
    it.grant = 0; it.err = 0; it.tag = req;
    if (op == 2'd2) m_lock[ref_sector(a)] = 1;
    else if (op == 2'd3) m_lock[ref_sector(a)] = 0;
    else if (prot || m_busy) it.err = 1;
    else begin
      it.grant = 1; m_busy = 1; m_bank = a[21:20];
    end
    it.busy = m_busy;
    it.bank = m_bank;
    q.push_back(it);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic finish_op();
    @(negedge clk_i);
    op_done_i = 1'b1;
    m_busy = 0;
    @(negedge clk_i);
    op_done_i = 1'b0;
    chk(busy_o === 1'b0, "R8", "busy_o after done", int'(busy_o), 0);
  endtask

  task automatic rd_look(logic [21:0] a, string req);
    bit e;
    @(negedge clk_i);
    rd_addr_i = a;
    #2;
    e = m_busy && (a[21:20] == m_bank);
    chk(rd_status_o === e, req, "rd_status_o", int'(rd_status_o), int'(e));
  endtask

  // monitor: compare registered results one cycle after each request
  initial begin
    forever begin
      bit v;
      item_t it;
      @(posedge clk_i);
      v = req_valid_i;
      #5;
      if (v) begin
        if (q.size() == 0) begin
          chk(1'b0, "R8", "scoreboard empty", 0, 1);
        end else begin
          it = q.pop_front();
          chk(grant_o === it.grant, it.tag, "grant_o", int'(grant_o), int'(it.grant));
          chk(err_o === it.err, it.tag, "err_o", int'(err_o), int'(it.err));
          chk(busy_o === it.busy, it.tag, "busy_o", int'(busy_o), int'(it.busy));
          if (it.busy)
            chk(busy_bank_o === it.bank, "R1", "busy_bank_o", int'(busy_bank_o), int'(it.bank));
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done_flag) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // reset state, R4: all lock bits clear
    chk(grant_o === 1'b0, "R8", "grant_o in reset", int'(grant_o), 0);
    chk(err_o === 1'b0, "R5", "err_o in reset", int'(err_o), 0);
    chk(busy_o === 1'b0, "R8", "busy_o in reset", int'(busy_o), 0);
    rst_ni = 1'b1;
    look(22'h000000, "R4");
    look(22'h1F0000, "R4");
    look(22'h3FE000, "R4");
    rd_look(22'h000000, "R10");

    // sector map sweep: R2 for general sectors, R3 for top boot
    for (int b = 0; b < 4; b++)
      for (int h = 0; h < 32; h++)
        for (int s = 0; s < 4; s++) begin
          logic [21:0] a;
          int e;
          a = {b[1:0], h[4:0], s[1:0], 13'h0A5};
          @(negedge clk_i);
          req_addr_i = a;
          #2;
          e = ref_sector(a);
          chk(int'(sector_o) == e, (b == 3 && h == 31) ? "R3" : "R2",
              "sector_o", int'(sector_o), e);
        end

    // R4 lock sector 5, neighbour stays free; R11 lock is quiet
    do_req(2'd2, 22'h010000, "R11");
    look(22'h010000, "R4");
    look(22'h008000, "R4");
    // R5 protected program rejected
    do_req(2'd0, 22'h010000, "R5");
    do_req(2'd3, 22'h010000, "R11");
    look(22'h010000, "R4");
    // R8 accepted program in bank 0
    do_req(2'd0, 22'h010000, "R8");
    rd_look(22'h0ABCDE, "R10");
    rd_look(22'h200000, "R10");
    rd_look(22'h3FFFFF, "R10");
    // R9 erase while busy
    do_req(2'd1, 22'h250000, "R9");
    rd_look(22'h012345, "R10");
    finish_op();
    rd_look(22'h012345, "R10");

    // R6 write-protect pin
    @(negedge clk_i) wp_ni = 1'b0;
    look(22'h002000, "R6");
    look(22'h004000, "R6");
    do_req(2'd0, 22'h002000, "R6");
    do_req(2'd3, 22'h002000, "R6");
    look(22'h002000, "R6");
    @(negedge clk_i) wp_ni = 1'b1;
    look(22'h002000, "R6");
    do_req(2'd0, 22'h002000, "R6");
    finish_op();

    // R7 acceleration pin
    @(negedge clk_i) acc_ni = 1'b0;
    look(22'h250000, "R7");
    look(22'h150000, "R7");
    do_req(2'd1, 22'h250000, "R7");
    @(negedge clk_i) acc_ni = 1'b1;
    look(22'h250000, "R7");

    // R3 top boot sector erase, then lock it
    do_req(2'd1, 22'h3FE000, "R3");
    rd_look(22'h3C0000, "R10");
    rd_look(22'h100000, "R10");
    finish_op();
    do_req(2'd2, 22'h3FE000, "R3");
    look(22'h3FE000, "R3");
    look(22'h3FC000, "R3");
    do_req(2'd1, 22'h3FE000, "R3");
    do_req(2'd0, 22'h3FC000, "R1");
    finish_op();

    repeat (3) @(negedge clk_i);
    chk(q.size() == 0, "R8", "scoreboard drained", q.size(), 0);
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule